// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers the interrupt events of a peripheral interface chip into one place. Each source delivers a one-cycle pulse. The pulse sets a sticky flag bit, and that bit stays set until the processor clears it. A matching enable register decides which pending flags may interrupt. The block drives a single request line, `irq_pull_low`. The pad drives it as an open-drain output, so it only pulls the shared interrupt wire low or lets it float, and several chips can share one request wire.

The processor uses a small register port with two locations. The flag location (address 0) holds the seven source flags in bits 6..0. Its bit 7 is a live summary that reads 1 whenever at least one enabled flag is pending, so polling software can find the interrupting chip with one read. Writing 1s to the flag location clears the matching flags. The enable location (address 1) uses bit 7 of the write data to choose between setting and clearing. Reads have no side effects and return data combinationally. This is a register interface, not a stream, so it has no valid/ready handshake.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every flag and every enable bit is 0, the flag location reads 0x00, the enable location reads 0x80 and `irq_pull_low` is 0.
- R2: A 1 on `src_evt[i]` at a clock edge sets flag i, which then reads back at bit i of the flag location. The flag stays set until it is cleared.
- R3: A write to the flag location (bus_sel=1, bus_wr=1, bus_addr=0) clears each flag whose data bit in 6..0 is 1. Flags written with 0 keep their value.
- R4: When a source event and a clear of the same flag land on the same edge, the flag is set after that edge.
- R5: A write to the enable location with data bit 7 = 1 sets each enable bit whose data bit in 6..0 is 1. The other enable bits do not change.
- R6: A write to the enable location with data bit 7 = 0 clears each enable bit whose data bit in 6..0 is 1. The other enable bits do not change.
- R7: `irq_pull_low` is 1 exactly when at least one flag and its enable bit are both 1.
- R8: Bit 7 of the flag location reads 1 exactly when at least one enabled flag is pending. Bits 6..0 read the flags.
- R9: The enable location reads with bit 7 always 1 and the enable bits in 6..0.
- R10: Bit 7 of a write to the flag location has no effect. A write to the enable location leaves the flags unchanged.
- R11: With bus_sel = 0, a write strobe changes neither flags nor enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 7 | One-cycle event pulses, one per source |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 1 | 0 = flag location, 1 = enable location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed location |
| irq_pull_low | output | 1 | 1 = pull the shared open-drain request wire low |

## Verification
The bench raises an event and clears the same flag on one edge. A design that gives the clear priority would lose that interrupt. It writes enable data with bit 7 at both values and with masks that overlap the bits already set. A design that decodes the set/clear bit wrongly, or that disturbs the unmasked bits, shows up on the next enable readback and on the request line. It checks the summary bit with pending flags that are masked and with flags that are enabled. A design that drops the enable from the summary would flag an interrupt that is not there. It also sends writes with bus_sel low and writes with bit 7 set to the flag location. A design that ignores these rules would clear or set state that must not change.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic {
    LOC_FLAG = 1'b0,
    LOC_ENA  = 1'b1
  } loc_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] flags
);
  // One sticky bit per source; a new event outranks a clear on the same edge.
  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= 1'b0;
      else if (src_evt[g]) q <= 1'b1;
      else if (clr_mask[g]) q <= 1'b0;
    end
    assign flags[g] = q;
  end

  // R2, R4: every event bit appears in the flags after the edge
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((flags & $past(src_evt)) == $past(src_evt)));
  // R3: cleared bits without an event drop
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~src_evt) != '0) |=> ((flags & $past(clr_mask & ~src_evt)) == '0));
  // R3: bits not cleared keep a set value
  a_r3_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~clr_mask)) == $past(flags & ~clr_mask)));
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int NSRC = 7,
  localparam int DW = NSRC + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [DW-1:0]   wdata,
  output logic [NSRC-1:0] ena
);
  logic            set_mode;
  logic [NSRC-1:0] sel_bits;
  logic [NSRC-1:0] ena_d;

  assign set_mode = wdata[DW-1];
  assign sel_bits = wdata[NSRC-1:0];

  always_comb begin
    ena_d = ena;
    if (wr_stb) ena_d = set_mode ? (ena | sel_bits) : (ena & ~sel_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ena <= '0;
    else        ena <= ena_d;
  end

  // R5: set mode raises each selected bit
  a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wdata[DW-1]) |=> ((ena & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));
  // R6: clear mode drops each selected bit
  a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wdata[DW-1]) |=> ((ena & $past(wdata[NSRC-1:0])) == '0));
  // R5, R6: unselected bits never move
  a_r6_others_stable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ena & ~$past(wr_stb ? wdata[NSRC-1:0] : '0)) == ($past(ena) & ~$past(wr_stb ? wdata[NSRC-1:0] : '0))));
endmodule

// File: rtl/irq_readout.sv
module irq_readout #(
  parameter int NSRC = 7,
  localparam int DW = NSRC + 1
) (
  input  logic            loc,
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] ena,
  output logic [DW-1:0]   rdata,
  output logic            pending
);
  import irq_agg_pkg::*;

  assign pending = |(flags & ena);

  always_comb begin
    if (loc_e'(loc) == LOC_ENA) rdata = {1'b1, ena};
    else                        rdata = {pending, flags};
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NSRC = 7,
  localparam int DW = NSRC + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic            bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_pull_low
);
  import irq_agg_pkg::*;

  logic            wr_any;
  logic            wr_flag;
  logic            wr_ena;
  logic [NSRC-1:0] clr_mask;
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] ena;
  logic            pending;

  assign wr_any   = bus_sel && bus_wr;
  assign wr_flag  = wr_any && (loc_e'(bus_addr) == LOC_FLAG);
  assign wr_ena   = wr_any && (loc_e'(bus_addr) == LOC_ENA);
  assign clr_mask = wr_flag ? bus_wdata[NSRC-1:0] : '0;

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .clr_mask(clr_mask), .flags(flags)
  );

  irq_enable_reg #(.NSRC(NSRC)) u_ena (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_ena), .wdata(bus_wdata), .ena(ena)
  );

  irq_readout #(.NSRC(NSRC)) u_rd (
    .loc(bus_addr), .flags(flags), .ena(ena), .rdata(bus_rdata), .pending(pending)
  );

  assign irq_pull_low = pending;

  // R8: the flag summary bit agrees with the request line
  a_r8_summary_is_request: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 1'b0) |-> (bus_rdata[DW-1] == irq_pull_low));
  // R9: enable readback has its top bit high
  a_r9_ena_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 1'b1) |-> bus_rdata[DW-1]);
  // R11: without select, flags only rise
  a_r11_nosel_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> ((flags & $past(flags)) == $past(flags)));
  // R7: no pending flag means the line is released
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq_pull_low);
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] src_evt = '0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_pull_low;

  always #4 clk = ~clk; // 125 MHz

  irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pull_low(irq_pull_low)
  );

  typedef struct {
    logic [7:0] rd;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;
  logic [6:0] mflag = '0;
  logic [6:0] men = '0;

  // Monitor: pops the expectations pushed in this cycle.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (bus_rdata !== e.rd || irq_pull_low !== e.irq) begin
        miscompares++;
        $display("FAIL %s rdata=%h irq=%b expected rdata=%h irq=%b",
                 e.tag, bus_rdata, irq_pull_low, e.rd, e.irq);
      end
    end
  end

  // Driver: applies one cycle and pushes the model's expectation.
  task automatic step(input logic [6:0] evt, input logic sel, input logic wr,
                      input logic addr, input logic [7:0] wd, input string tag);
    exp_t e;
    logic [6:0] clr;
    @(posedge clk);
    #1;
    src_evt = evt; bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    e.irq = |(mflag & men);
    e.rd  = addr ? {1'b1, men} : {e.irq, mflag};
    e.tag = tag;
    q.push_back(e);
    clr = (sel && wr && !addr) ? wd[6:0] : 7'h0;
    mflag = (mflag & ~clr) | evt;
    if (sel && wr && addr) men = wd[7] ? (men | wd[6:0]) : (men & ~wd[6:0]);
  endtask

  task automatic rd(input logic addr, input string tag);
    step(7'h0, 1'b0, 1'b0, addr, 8'h00, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(1'b0, "R1 flag reset");
    rd(1'b1, "R1 enable reset");
    step(7'h05, 1'b0, 1'b0, 1'b0, 8'h00, "R2 event");
    rd(1'b0, "R2 flags latched");
    rd(1'b0, "R2 flags sticky");
    step(7'h0, 1'b0, 1'b1, 1'b1, 8'hFF, "R11 unselected enable write");
    rd(1'b1, "R11 enables unchanged");
    step(7'h0, 1'b0, 1'b1, 1'b0, 8'h7F, "R11 unselected flag write");
    rd(1'b0, "R11 flags unchanged");
    rd(1'b1, "R9 top bit with no enables");
    step(7'h0, 1'b1, 1'b1, 1'b1, 8'h81, "R5 set bit0");
    rd(1'b0, "R7 R8 enabled pending");
    rd(1'b1, "R5 enable readback");
    step(7'h0, 1'b1, 1'b1, 1'b1, 8'h01, "R6 clear bit0");
    rd(1'b0, "R8 masked pending");
    step(7'h0, 1'b1, 1'b1, 1'b1, 8'h85, "R5 set bits 0 2");
    step(7'h0, 1'b1, 1'b1, 1'b1, 8'h04, "R6 clear bit2");
    rd(1'b1, "R6 others kept");
    step(7'h0, 1'b1, 1'b1, 1'b0, 8'h01, "R3 clear flag0");
    rd(1'b0, "R3 flag2 kept");
    step(7'h0, 1'b1, 1'b1, 1'b0, 8'h00, "R3 zero write");
    rd(1'b0, "R3 nothing cleared");
    step(7'h0, 1'b1, 1'b1, 1'b0, 8'h80, "R10 top bit write");
    rd(1'b0, "R10 flags unchanged");
    step(7'h0, 1'b1, 1'b1, 1'b1, 8'hC8, "R10 enable write");
    rd(1'b0, "R10 flags after enable write");
    step(7'h08, 1'b1, 1'b1, 1'b0, 8'h08, "R4 event and clear");
    rd(1'b0, "R4 flag kept");
    rd(1'b1, "R9 enable readback");
    for (int i = 0; i < 300; i++) begin
      step(7'($urandom()) & 7'($urandom()), 1'($urandom()), 1'($urandom()),
           1'($urandom()), 8'($urandom()), "R7 R8 mixed traffic");
    end
    @(posedge clk);
    @(negedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule